// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block issues a single SD card command over an SPI byte link and collects the card's reply. The requester presents a 6-bit command index, a 32-bit argument, a check byte, a flag that asks for a 32-bit trailing word after the status byte, and a flag that keeps chip select low when the command finishes. The engine then runs the whole exchange through a start/done byte port to an SPI master (mode 0, MSB first) and drives the active-low chip select itself.

An accepted request pulls chip select low and spends one filler byte of settling time. The engine then shifts out the six-byte command frame and clocks filler bytes until the card returns a status byte with its top bit clear. It reads the optional trailing word, releases the bus with one more filler byte, and pulses `done`. The status byte, the trailing word, two decoded status flags and a timeout flag stay on the outputs until the next request is accepted. Chip select can be left low so that a data-block reader working on the same SPI link can continue the transaction.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: After a request is accepted, the first byte exchanged is 0xFF with `cs_n` low. Six frame bytes follow, also with `cs_n` low: 0x40 OR the command index, the argument bytes from bits 31:24 down to bits 7:0, and then the check byte.
- R2: After the frame the engine transmits only 0xFF bytes. The first received byte with bit 7 clear is the status byte and appears on `r1`. Received bytes with bit 7 set are skipped.
- R3: At most MAX_POLL (default 5000) status polls are made. If none of them returns bit 7 clear, `timeout` goes to 1, `r1` reads 0xFF, `cs_n` goes high, one 0xFF byte is exchanged with `cs_n` high, and then `done` pulses.
- R4: When `req_word` is 1, the four bytes received after the status byte are packed into `resp_word`, with the first byte in bits 31:24. When `req_word` is 0, no extra byte is exchanged and `resp_word` reads 0.
- R5: When `req_hold_cs` is 0, `cs_n` rises after the reply and one 0xFF byte is exchanged with `cs_n` high before `done`. When `req_hold_cs` is 1 and the command does not time out, `cs_n` stays low at `done` and that trailing byte is left out.
- R6: `r1_in_idle` is 1 exactly when a status byte was received and its bit 0 is 1. `r1_fault` is 1 exactly when a status byte was received and any of its bits 2 to 6 is 1 (illegal command, CRC, erase sequence, address, parameter). Bit 1 (erase reset) does not affect either flag.
- R7: `req_ready` is 1 only while the engine is idle. A `req_valid` seen while `req_ready` is 0 has no effect. At most one byte exchange is outstanding: `spi_start` stays low until the previous `spi_done` has been seen.
- R8: Reset puts `cs_n` at 1, `req_ready` at 1, and `done`, `timeout` and `spi_start` at 0. `done` is a one-cycle pulse that is high in the cycle that follows the clock edge at which the final `spi_done` was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_cmd | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_chk | input | 8 | Check byte placed last in the frame |
| req_word | input | 1 | Read four trailing bytes after the status byte |
| req_hold_cs | input | 1 | Leave chip select low after the reply |
| spi_start | output | 1 | Starts one byte exchange |
| spi_tx | output | 8 | Byte to transmit, valid with `spi_start` |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Received byte, valid with `spi_done` |
| cs_n | output | 1 | Card chip select, active low |
| r1 | output | 8 | Captured status byte (0xFF if none) |
| r1_in_idle | output | 1 | Card reports initialisation in progress |
| r1_fault | output | 1 | Card reports any error bit |
| resp_word | output | 32 | Trailing word, first byte most significant |
| timeout | output | 1 | No status byte within the poll limit |
| done | output | 1 | One-cycle completion pulse |

## Verification
All results are due together. `done`, `r1`, `resp_word`, `timeout` and the final state of `cs_n` are valid in the cycle that follows the clock edge that took the final `spi_done`, and `done` is low again one cycle later. The bench's card model answers each `spi_start` two falling edges later. The bench stamps that edge with a cycle counter and samples every result on falling edges. It checks that `done` appears exactly one cycle after the stamped edge and is gone on the next falling edge. Frame bytes, chip-select levels and the number of exchanges are logged at each `spi_start`, so byte order and the trailing-byte rule are checked per exchange rather than only at the end.

// File: rtl/sdspi_cmd_pkg.sv
package sdspi_cmd_pkg;

    localparam int          FRAME_LEN = 6;
    localparam logic [7:0]  FILL_BYTE = 8'hFF;
    localparam logic [7:0]  CMD_MARK  = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_FRAME,
        ST_POLL,
        ST_EXTRA,
        ST_TAIL
    } eng_state_e;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [7:0]  chk;
        logic        want_word;
        logic        hold_cs;
    } sd_req_t;

    // Byte at position pos (0..5) of the outgoing command frame.
    function automatic logic [7:0] frame_byte(sd_req_t rq, logic [2:0] pos);
        logic [7:0] b;
        case (pos)
            3'd0:    b = CMD_MARK | {2'b00, rq.idx};
            3'd1:    b = rq.arg[31:24];
            3'd2:    b = rq.arg[23:16];
            3'd3:    b = rq.arg[15:8];
            3'd4:    b = rq.arg[7:0];
            default: b = rq.chk;
        endcase
        return b;
    endfunction

    // A status byte is valid only when its top bit is clear.
    function automatic logic stat_valid(logic [7:0] s);
        return ~s[7];
    endfunction

    function automatic logic stat_idle(logic [7:0] s);
        return stat_valid(s) & s[0];
    endfunction

    // Error group: illegal command, CRC, erase sequence, address, parameter.
    function automatic logic stat_fault(logic [7:0] s);
        return stat_valid(s) & (|s[6:2]);
    endfunction

endpackage

// File: rtl/sdspi_frame_mux.sv
module sdspi_frame_mux
    import sdspi_cmd_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  sd_req_t          req,
    input  logic             sel_frame,
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       tx_byte
);
    always_comb begin
        tx_byte = FILL_BYTE;
        if (sel_frame) begin
            tx_byte = frame_byte(req, pos[2:0]);
        end
    end
endmodule

// File: rtl/sdspi_poll_counter.sv
module sdspi_poll_counter #(
    parameter int MAX_POLL = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    output logic last_try
);
    localparam int CNT_W = $clog2(MAX_POLL + 1);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLL - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_try = (cnt_q == LAST_VAL);
endmodule

// File: rtl/sdspi_resp_capture.sv
module sdspi_resp_capture
    import sdspi_cmd_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load_stat,
    input  logic              shift_word,
    input  logic [7:0]        rx,
    output logic [7:0]        stat,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stat <= FILL_BYTE;
            word <= '0;
        end else begin
            if (load_stat) begin
                stat <= rx;
            end
            if (shift_word) begin
                word <= {word[WORD_W-9:0], rx};
            end
        end
    end
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
    import sdspi_cmd_pkg::*;
#(
    parameter int MAX_POLL    = 5000,
    parameter int EXTRA_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [5:0]               req_cmd,
    input  logic [31:0]              req_arg,
    input  logic [7:0]               req_chk,
    input  logic                     req_word,
    input  logic                     req_hold_cs,
    output logic                     spi_start,
    output logic [7:0]               spi_tx,
    input  logic                     spi_done,
    input  logic [7:0]               spi_rx,
    output logic                     cs_n,
    output logic [7:0]               r1,
    output logic                     r1_in_idle,
    output logic                     r1_fault,
    output logic [8*EXTRA_BYTES-1:0] resp_word,
    output logic                     timeout,
    output logic                     done
);
    localparam int WORD_W  = 8 * EXTRA_BYTES;
    localparam int POS_MAX = (FRAME_LEN > EXTRA_BYTES) ? FRAME_LEN : EXTRA_BYTES;
    localparam int POS_W   = $clog2(POS_MAX);
    localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] EXTRA_LAST = POS_W'(EXTRA_BYTES - 1);

    eng_state_e       st_q;
    sd_req_t          req_q;
    logic [POS_W-1:0] pos_q;
    logic             wait_q;
    logic             cs_n_q;
    logic             done_q;
    logic             tmo_q;

    logic accept;
    logic byte_back;
    logic poll_hit;
    logic last_try;

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign spi_start = (st_q != ST_IDLE) && !wait_q;
    assign byte_back = wait_q && spi_done;
    assign poll_hit  = (st_q == ST_POLL) && byte_back && stat_valid(spi_rx);

    sdspi_frame_mux #(.POS_W(POS_W)) u_mux (
        .req       (req_q),
        .sel_frame (st_q == ST_FRAME),
        .pos       (pos_q),
        .tx_byte   (spi_tx)
    );

    sdspi_poll_counter #(.MAX_POLL(MAX_POLL)) u_poll (
        .clk      (clk),
        .rst      (rst),
        .clr      (accept),
        .step     ((st_q == ST_POLL) && byte_back),
        .last_try (last_try)
    );

    sdspi_resp_capture #(.WORD_W(WORD_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .clr        (accept),
        .load_stat  (poll_hit),
        .shift_word ((st_q == ST_EXTRA) && byte_back),
        .rx         (spi_rx),
        .stat       (r1),
        .word       (resp_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            pos_q  <= '0;
            wait_q <= 1'b0;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (req_valid) begin
                    req_q  <= '{idx: req_cmd, arg: req_arg, chk: req_chk,
                               want_word: req_word, hold_cs: req_hold_cs};
                    cs_n_q <= 1'b0;
                    tmo_q  <= 1'b0;
                    pos_q  <= '0;
                    st_q   <= ST_LEAD;
                end
            end else if (!wait_q) begin
                wait_q <= 1'b1;
            end else if (spi_done) begin
                wait_q <= 1'b0;
                case (st_q)
                    ST_LEAD: begin
                        pos_q <= '0;
                        st_q  <= ST_FRAME;
                    end
                    ST_FRAME: begin
                        if (pos_q == FRAME_LAST) begin
                            pos_q <= '0;
                            st_q  <= ST_POLL;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                    ST_POLL: begin
                        if (stat_valid(spi_rx)) begin
                            if (req_q.want_word) begin
                                pos_q <= '0;
                                st_q  <= ST_EXTRA;
                            end else if (req_q.hold_cs) begin
                                done_q <= 1'b1;
                                st_q   <= ST_IDLE;
                            end else begin
                                cs_n_q <= 1'b1;
                                st_q   <= ST_TAIL;
                            end
                        end else if (last_try) begin
                            tmo_q  <= 1'b1;
                            cs_n_q <= 1'b1;
                            st_q   <= ST_TAIL;
                        end
                    end
                    ST_EXTRA: begin
                        if (pos_q != EXTRA_LAST) begin
                            pos_q <= pos_q + 1'b1;
                        end else if (req_q.hold_cs) begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            cs_n_q <= 1'b1;
                            st_q   <= ST_TAIL;
                        end
                    end
                    default: begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    assign cs_n       = cs_n_q;
    assign done       = done_q;
    assign timeout    = tmo_q;
    assign r1_in_idle = stat_idle(r1);
    assign r1_fault   = stat_fault(r1);
endmodule

// File: rtl/sdspi_cmd_engine_chk.sv
module sdspi_cmd_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       spi_start,
    input logic       spi_done,
    input logic       cs_n,
    input logic [7:0] r1,
    input logic       timeout,
    input logic       done
);
    logic pending_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= 1'b0;
        end else if (spi_start) begin
            pending_q <= 1'b1;
        end else if (spi_done) begin
            pending_q <= 1'b0;
        end
    end

    a_r7_single_exchange: assert property (@(posedge clk) disable iff (rst)
        spi_start |-> !pending_q);

    a_r7_not_ready_while_pending: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> !req_ready);

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_after_byte: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(spi_done));

    a_r3_timeout_releases_cs: assert property (@(posedge clk) disable iff (rst)
        (done && timeout) |-> cs_n);

    a_r2_status_msb_clear: assert property (@(posedge clk) disable iff (rst)
        (done && !timeout) |-> !r1[7]);
endmodule

bind sdspi_cmd_engine sdspi_cmd_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .spi_start (spi_start),
    .spi_done  (spi_done),
    .cs_n      (cs_n),
    .r1        (r1),
    .timeout   (timeout),
    .done      (done)
);

// File: tb/sdspi_cmd_engine_bench.sv
module sdspi_cmd_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 5000;
    localparam int NVEC       = 7;

    typedef struct packed {
        logic [5:0]  cmd;
        logic [31:0] arg;
        logic [7:0]  chk;
        logic        want;
        logic        hold;
        logic [15:0] busy;
        logic [7:0]  stat;
        logic [31:0] word;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{6'd0,  32'h0000_0000, 8'h95, 1'b0, 1'b0, 16'd2,    8'h01, 32'h0},
        '{6'd8,  32'h0000_01AA, 8'h87, 1'b1, 1'b0, 16'd0,    8'h01, 32'h0000_01AA},
        '{6'd58, 32'h0000_0000, 8'hFD, 1'b1, 1'b0, 16'd3,    8'h00, 32'hC0FF_8000},
        '{6'd9,  32'h0000_0000, 8'hAF, 1'b0, 1'b1, 16'd1,    8'h00, 32'h0},
        '{6'd17, 32'h1234_5678, 8'h01, 1'b0, 1'b0, 16'd0,    8'h04, 32'h0},
        '{6'd16, 32'h0000_0200, 8'h15, 1'b0, 1'b0, 16'd5,    8'h02, 32'h0},
        '{6'd41, 32'h4000_0000, 8'h77, 1'b0, 1'b0, 16'd4999, 8'h00, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_cmd = '0;
    logic [31:0] req_arg = '0;
    logic [7:0]  req_chk = '0;
    logic        req_word = 1'b0;
    logic        req_hold_cs = 1'b0;
    logic        spi_start;
    logic [7:0]  spi_tx;
    logic        spi_done = 1'b0;
    logic [7:0]  spi_rx = 8'hFF;
    logic        cs_n;
    logic [7:0]  r1;
    logic        r1_in_idle;
    logic        r1_fault;
    logic [31:0] resp_word;
    logic        timeout;
    logic        done;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdspi_cmd_engine u_sdspi_cmd_engine (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_arg(req_arg), .req_chk(req_chk),
        .req_word(req_word), .req_hold_cs(req_hold_cs),
        .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done),
        .spi_rx(spi_rx), .cs_n(cs_n), .r1(r1), .r1_in_idle(r1_in_idle),
        .r1_fault(r1_fault), .resp_word(resp_word), .timeout(timeout),
        .done(done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // card model state
    int          n_xfer = 0;
    int          m_busy = 0;
    logic [7:0]  m_stat = 8'hFF;
    logic [31:0] m_word = '0;
    logic [7:0]  tx_log [16];
    logic        cs_log [16];
    logic [7:0]  last_tx = 8'h00;
    logic        last_cs = 1'b0;
    bit          poll_bad = 1'b0;

    int cyc = 0;
    int last_done_cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (spi_done) last_done_cyc <= cyc;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] card_byte(input int k);
        int p;
        int j;
        if (k < 7) return 8'hFF;
        p = k - 7;
        if (p < m_busy) return 8'hFF;
        if (p == m_busy) return m_stat;
        j = p - m_busy - 1;
        if (j < 4) return m_word[31-8*j -: 8];
        return 8'hFF;
    endfunction

    // card model: answers each start two falling edges later
    initial begin
        @(negedge clk);
        forever begin
            if (spi_start === 1'b1) begin
                int k;
                k = n_xfer;
                if (k < 16) begin
                    tx_log[k] = spi_tx;
                    cs_log[k] = cs_n;
                end
                if (k >= 7 && spi_tx !== 8'hFF) poll_bad = 1'b1;
                last_tx = spi_tx;
                last_cs = cs_n;
                n_xfer++;
                @(negedge clk);
                spi_rx   = card_byte(k);
                spi_done = 1'b1;
                @(negedge clk);
                spi_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic issue(input vec_t v);
        @(negedge clk);
        n_xfer   = 0;
        poll_bad = 1'b0;
        m_busy   = int'(v.busy);
        m_stat   = v.stat;
        m_word   = v.word;
        req_cmd  = v.cmd;
        req_arg  = v.arg;
        req_chk  = v.chk;
        req_word = v.want;
        req_hold_cs = v.hold;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40000; i++) begin
            if (done === 1'b1) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!ok) check("R8 done never seen", 32'd0, 32'd1);
    endtask

    task automatic check_frame(input vec_t v);
        bit cs_ok;
        cs_ok = 1'b1;
        for (int i = 0; i < 7; i++) if (cs_log[i] !== 1'b0) cs_ok = 1'b0;
        check("R1 lead byte", {24'd0, tx_log[0]}, 32'hFF);
        check("R1 cs low over lead and frame", {31'd0, cs_ok}, 32'd1);
        check("R1 command byte", {24'd0, tx_log[1]}, {24'd0, 8'h40 | {2'b00, v.cmd}});
        check("R1 argument bytes", {tx_log[2], tx_log[3], tx_log[4], tx_log[5]}, v.arg);
        check("R1 check byte", {24'd0, tx_log[6]}, {24'd0, v.chk});
    endtask

    task automatic run_vec(input vec_t v);
        bit ok;
        int exp_n;
        issue(v);
        wait_done(ok);
        if (!ok) return;
        exp_n = 7 + int'(v.busy) + 1 + (v.want ? 4 : 0) + (v.hold ? 0 : 1);
        check("R8 done one cycle after final byte", cyc, last_done_cyc + 1);
        check_frame(v);
        check("R2 status byte", {24'd0, r1}, {24'd0, v.stat});
        check("R2 poll bytes all 0xFF", {31'd0, poll_bad}, 32'd0);
        check("R3 no timeout", {31'd0, timeout}, 32'd0);
        check("R4 trailing word", resp_word, v.want ? v.word : 32'd0);
        check("R5 exchange count", exp_n, n_xfer);
        check("R5 cs at done", {31'd0, cs_n}, {31'd0, !v.hold});
        if (!v.hold) begin
            check("R5 trailing byte value", {24'd0, last_tx}, 32'hFF);
            check("R5 trailing byte cs high", {31'd0, last_cs}, 32'd1);
        end
        check("R6 idle flag", {31'd0, r1_in_idle}, {31'd0, v.stat[0]});
        check("R6 fault flag", {31'd0, r1_fault}, {31'd0, |v.stat[6:2]});
        @(negedge clk);
        check("R8 done single cycle", {31'd0, done}, 32'd0);
        check("R7 ready after done", {31'd0, req_ready}, 32'd1);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        vec_t vt;
        bit ok;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 reset cs_n", {31'd0, cs_n}, 32'd1);
        check("R8 reset ready", {31'd0, req_ready}, 32'd1);
        check("R8 reset done/timeout/start", {29'd0, done, timeout, spi_start}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R3: card never answers
        vt = '{6'd55, 32'h0, 8'h65, 1'b0, 1'b1, 16'd6000, 8'h00, 32'h0};
        issue(vt);
        wait_done(ok);
        if (ok) begin
            check("R3 timeout flag", {31'd0, timeout}, 32'd1);
            check("R3 status reads 0xFF", {24'd0, r1}, 32'hFF);
            check("R3 poll bound exchange count", n_xfer, 7 + MAXP + 1);
            check("R3 cs released", {31'd0, cs_n}, 32'd1);
            check("R3 trailing byte cs high", {31'd0, last_cs}, 32'd1);
            check("R6 flags clear on timeout", {30'd0, r1_in_idle, r1_fault}, 32'd0);
        end

        // R7: a request while busy is ignored
        vt = '{6'd13, 32'hA5A5_0001, 8'h33, 1'b0, 1'b0, 16'd10, 8'h00, 32'h0};
        issue(vt);
        repeat (6) @(negedge clk);
        check("R7 not ready while busy", {31'd0, req_ready}, 32'd0);
        req_cmd = 6'd24;
        req_arg = 32'hDEAD_BEEF;
        req_word = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(ok);
        if (ok) begin
            check("R7 frame from first request", {24'd0, tx_log[1]}, 32'h4D);
            check("R7 argument from first request", {tx_log[2], tx_log[3], tx_log[4], tx_log[5]}, 32'hA5A5_0001);
            check("R7 no word phase from ignored request", n_xfer, 7 + 11 + 1);
        end
        repeat (20) @(negedge clk);
        check("R7 no second transaction", n_xfer, 19);
        check("R7 idle after ignored request", {31'd0, req_ready}, 32'd1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule